// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This peripheral sits on a 32-bit register bus and owns a 512-word on-chip buffer. Software loads or unloads the buffer with ordinary word accesses. It then writes a byte length and a starting word index, and launches a block transfer between the buffer and an internal configuration port by writing a direction value. Direction 0 streams buffer words out to the port, which is configuration. Direction 1 captures words arriving from the port into the buffer, which is readback.

A status word reports whether the last transfer has completed. It also carries four constant-one padding bits and four live flags that come straight from the port. Writing the status word aborts any transfer in flight. The port uses valid/ready handshakes: an outgoing channel for configuration data and an incoming channel for readback data.

Bus reads return data one cycle after the request. The transfer length is the byte count divided by four. The buffer word index wraps at the buffer depth.

Top module: `cfgbuf_ctrl`

## Requirements
- R1: Buffer word n is read and written at bus byte address n*4 (0x000 to 0x7FC). Read data appears on `bus_rdata` in the cycle after the read request.
- R2: The length register at 0x800 reads back all 32 written bits. The start-index register at 0x804 keeps only bits 8:0 and reads back zero-extended.
- R3: Writing 0x808 with bit 0 = 0 streams length/4 buffer words, starting at the start index, out of `cfg_out_data` in ascending order. One word moves per valid/ready handshake. Valid and data hold steady while ready is low.
- R4: Writing 0x808 with bit 0 = 1 raises `rb_in_ready`. Each word taken while `rb_in_valid` is high is stored at the next consecutive buffer index. Words outside that range are not touched. `rb_in_ready` is never high together with `cfg_out_valid`.
- R5: Status bit 0 (at 0x80C) is 1 after reset. It is 0 while a transfer runs, and 1 again from the cycle after the final word's handshake. While it is 1 there is no port activity.
- R6: Status bits 4:1 read 1111. Bit 5 reflects `port_abort_n`, bit 6 `port_rb_busy`, bit 7 `port_synced` and bit 8 `port_err`. Bits 31:9 read 0.
- R7: A length below 4 bytes completes at once: status bit 0 stays 1 and no port handshake is offered.
- R8: The buffer index advances by one per word and wraps from 511 to 0.
- R9: A write to 0x808 while a transfer is running is ignored. The running transfer continues unchanged in its original direction.
- R10: Any write to 0x80C aborts a running transfer. In the next cycle the port signals are idle and status bit 0 is 1. Buffer contents are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| cfg_out_valid | output | 1 | Configuration word offered |
| cfg_out_ready | input | 1 | Port accepts configuration word |
| cfg_out_data | output | 32 | Configuration word |
| rb_in_valid | input | 1 | Readback word offered by port |
| rb_in_ready | output | 1 | Controller accepts readback word |
| rb_in_data | input | 32 | Readback word |
| port_abort_n | input | 1 | Port abort flag, active low |
| port_rb_busy | input | 1 | Port readback-in-progress flag |
| port_synced | input | 1 | Port data-aligned flag |
| port_err | input | 1 | Port configuration-error flag |

## Verification
The bench builds the block with its default depth of 512 words, so the full 0x800 register boundary and the 511-to-0 index wrap are exercised at their real addresses. A readback placed a few words from a known untouched word shows that the write range stops exactly at length/4. Holding the port's ready low keeps a transfer running for as long as the bench needs, which lets it place ignored direction writes and aborts in the middle of a transfer.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;
  typedef enum logic [1:0] {
    REG_LEN   = 2'd0,
    REG_START = 2'd1,
    REG_DIR   = 2'd2,
    REG_STAT  = 2'd3
  } reg_idx_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_SEND,
    SQ_RECV
  } seq_state_e;

  localparam logic [3:0] STAT_PAD = 4'hF;
endpackage

// File: rtl/cfgbuf_mem.sv
module cfgbuf_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] store [DEPTH];
  logic          a_wr, b_wr;

  always_comb begin
    b_wr = b_en && b_we;
    a_wr = a_en && a_we && !(b_wr && (b_addr == a_addr));
  end

  always_ff @(posedge clk) begin
    if (a_wr) store[a_addr] <= a_wdata;
    if (b_wr) store[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_q <= store[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en && !b_we) b_q <= store[b_addr];
  end
endmodule

// File: rtl/cfgbuf_regs.sv
module cfgbuf_regs
  import cfgbuf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int WADDR_W = 9,
  localparam int BUS_AW = WADDR_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               buf_en,
  output logic               buf_we,
  output logic [WADDR_W-1:0] buf_addr,
  output logic [DW-1:0]      buf_wdata,
  input  logic [DW-1:0]      buf_q,
  input  logic               xfer_done,
  input  logic               port_abort_n,
  input  logic               port_rb_busy,
  input  logic               port_synced,
  input  logic               port_err,
  output logic               start,
  output logic               start_rb,
  output logic               abort,
  output logic [DW-1:0]      len_q,
  output logic [WADDR_W-1:0] first_q
);
  logic           is_reg, wr, rd;
  reg_idx_e       idx;
  logic           len_en, first_en;
  logic [DW-1:0]  stat_word, rd_val;
  logic           src_buf_q;
  logic [DW-1:0]  rreg_q;

  always_comb begin
    is_reg    = bus_addr[BUS_AW-1];
    idx       = reg_idx_e'(bus_addr[3:2]);
    wr        = bus_sel && bus_we && is_reg;
    rd        = bus_sel && !bus_we;
    buf_en    = bus_sel && !is_reg;
    buf_we    = bus_we;
    buf_addr  = bus_addr[WADDR_W+1:2];
    buf_wdata = bus_wdata;
    len_en    = wr && (idx == REG_LEN);
    first_en  = wr && (idx == REG_START);
    start     = wr && (idx == REG_DIR);
    start_rb  = bus_wdata[0];
    abort     = wr && (idx == REG_STAT);

    stat_word      = '0;
    stat_word[0]   = xfer_done;
    stat_word[4:1] = STAT_PAD;
    stat_word[5]   = port_abort_n;
    stat_word[6]   = port_rb_busy;
    stat_word[7]   = port_synced;
    stat_word[8]   = port_err;

    unique case (idx)
      REG_LEN:   rd_val = len_q;
      REG_START: rd_val = {{(DW-WADDR_W){1'b0}}, first_q};
      REG_STAT:  rd_val = stat_word;
      default:   rd_val = '0;
    endcase

    bus_rdata = src_buf_q ? buf_q : rreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      first_q <= '0;
    end else begin
      if (len_en)   len_q   <= bus_wdata;
      if (first_en) first_q <= bus_wdata[WADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_buf_q <= 1'b0;
      rreg_q    <= '0;
    end else if (rd) begin
      src_buf_q <= !is_reg;
      if (is_reg) rreg_q <= rd_val;
    end
  end
endmodule

// File: rtl/cfgbuf_seq.sv
module cfgbuf_seq
  import cfgbuf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int WADDR_W = 9,
  localparam int CW     = DW - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rb,
  input  logic               abort,
  input  logic [DW-1:0]      len,
  input  logic [WADDR_W-1:0] first,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_q,
  output logic               cfg_out_valid,
  input  logic               cfg_out_ready,
  output logic [DW-1:0]      cfg_out_data,
  input  logic               rb_in_valid,
  output logic               rb_in_ready,
  input  logic [DW-1:0]      rb_in_data,
  output logic               done
);
  seq_state_e         state_q, state_d;
  logic [WADDR_W-1:0] idx_q, idx_d;
  logic [CW-1:0]      left_q, left_d;
  logic               done_q, done_d;
  logic [CW-1:0]      words;
  logic               step, last;

  always_comb begin
    words     = len[DW-1:2];
    state_d   = state_q;
    idx_d     = idx_q;
    left_d    = left_q;
    done_d    = done_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = idx_q;
    mem_wdata = rb_in_data;
    step      = 1'b0;
    last      = (left_q == CW'(1));

    unique case (state_q)
      SQ_IDLE: begin
        if (start && (words != '0)) begin
          idx_d   = first;
          left_d  = words;
          done_d  = 1'b0;
          state_d = start_rb ? SQ_RECV : SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        mem_en  = 1'b1;
        state_d = SQ_SEND;
      end
      SQ_SEND: begin
        if (cfg_out_ready) begin
          step    = 1'b1;
          state_d = last ? SQ_IDLE : SQ_FETCH;
        end
      end
      SQ_RECV: begin
        if (rb_in_valid) begin
          mem_en  = !abort;
          mem_we  = 1'b1;
          step    = 1'b1;
          state_d = last ? SQ_IDLE : SQ_RECV;
        end
      end
      default: state_d = SQ_IDLE;
    endcase

    if (step) begin
      idx_d  = idx_q + 1'b1;
      left_d = left_q - 1'b1;
      if (last) done_d = 1'b1;
    end

    if (abort) begin
      state_d = SQ_IDLE;
      done_d  = 1'b1;
    end

    cfg_out_valid = (state_q == SQ_SEND);
    cfg_out_data  = mem_q;
    rb_in_ready   = (state_q == SQ_RECV);
    done          = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (idx_d != idx_q)   idx_q  <= idx_d;
      if (left_d != left_q) left_q <= left_d;
    end
  end
endmodule

// File: rtl/cfgbuf_ctrl.sv
module cfgbuf_ctrl #(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  localparam int WADDR_W  = $clog2(BUF_WORDS),
  localparam int BUS_AW   = WADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cfg_out_valid,
  input  logic              cfg_out_ready,
  output logic [DATA_W-1:0] cfg_out_data,
  input  logic              rb_in_valid,
  output logic              rb_in_ready,
  input  logic [DATA_W-1:0] rb_in_data,
  input  logic              port_abort_n,
  input  logic              port_rb_busy,
  input  logic              port_synced,
  input  logic              port_err
);
  logic               rst_meta_n, rst_sync_n;
  logic               a_en, a_we, b_en, b_we;
  logic [WADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0]  a_wdata, a_q, b_wdata, b_q;
  logic               start, start_rb, abort, xfer_done;
  logic [DATA_W-1:0]  len_q;
  logic [WADDR_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cfgbuf_regs #(.DW(DATA_W), .WADDR_W(WADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .buf_en(a_en), .buf_we(a_we), .buf_addr(a_addr),
    .buf_wdata(a_wdata), .buf_q(a_q),
    .xfer_done(xfer_done),
    .port_abort_n(port_abort_n), .port_rb_busy(port_rb_busy),
    .port_synced(port_synced), .port_err(port_err),
    .start(start), .start_rb(start_rb), .abort(abort),
    .len_q(len_q), .first_q(first_q)
  );

  cfgbuf_mem #(.DW(DATA_W), .DEPTH(BUF_WORDS)) u_mem (
    .clk(clk),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_q(a_q),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q)
  );

  cfgbuf_seq #(.DW(DATA_W), .WADDR_W(WADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start(start), .start_rb(start_rb), .abort(abort),
    .len(len_q), .first(first_q),
    .mem_en(b_en), .mem_we(b_we), .mem_addr(b_addr),
    .mem_wdata(b_wdata), .mem_q(b_q),
    .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_out_data(cfg_out_data),
    .rb_in_valid(rb_in_valid), .rb_in_ready(rb_in_ready),
    .rb_in_data(rb_in_data),
    .done(xfer_done)
  );
endmodule

// File: rtl/cfgbuf_ctrl_chk.sv
module cfgbuf_ctrl_chk #(
  parameter int DW     = 32,
  parameter int BUS_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [DW-1:0]     len_q,
  input logic              cfg_out_valid,
  input logic              cfg_out_ready,
  input logic [DW-1:0]     cfg_out_data,
  input logic              rb_in_ready,
  input logic              xfer_done
);
  localparam logic [BUS_AW-1:0] DIR_A  = BUS_AW'((1 << (BUS_AW-1)) + 8);
  localparam logic [BUS_AW-1:0] STAT_A = BUS_AW'((1 << (BUS_AW-1)) + 12);

  logic dir_wr, stat_wr;
  always_comb begin
    dir_wr  = bus_sel && bus_we && (bus_addr == DIR_A);
    stat_wr = bus_sel && bus_we && (bus_addr == STAT_A);
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out_valid && !cfg_out_ready && !stat_wr) |=> (cfg_out_valid && $stable(cfg_out_data)));

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_out_valid && rb_in_ready));

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!cfg_out_valid && !rb_in_ready));

  // R5
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_done) |-> $past(dir_wr));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_wr && xfer_done && (len_q[DW-1:2] == '0)) |=> xfer_done);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (xfer_done && !cfg_out_valid && !rb_in_ready));
endmodule

bind cfgbuf_ctrl cfgbuf_ctrl_chk #(.DW(DATA_W), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .len_q(len_q),
  .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
  .cfg_out_data(cfg_out_data),
  .rb_in_ready(rb_in_ready), .xfer_done(xfer_done)
);

// File: tb/cfgbuf_ctrl_bench.sv
module cfgbuf_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_LEN = 12'h800, A_FIRST = 12'h804,
                          A_DIR = 12'h808, A_STAT = 12'h80C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cfg_out_valid, cfg_out_ready = 1'b0;
  logic [31:0] cfg_out_data;
  logic        rb_in_valid = 1'b0, rb_in_ready;
  logic [31:0] rb_in_data = '0;
  logic        port_abort_n = 1'b1, port_rb_busy = 1'b0;
  logic        port_synced = 1'b1, port_err = 1'b0;

  int          n_chk = 0, n_err = 0;
  int          rdy_mode = 0;
  int          tick = 0;
  logic [31:0] bm [512];
  logic [31:0] expq [$];

  cfgbuf_ctrl u_cfgbuf_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_out_data(cfg_out_data),
    .rb_in_valid(rb_in_valid), .rb_in_ready(rb_in_ready), .rb_in_data(rb_in_data),
    .port_abort_n(port_abort_n), .port_rb_busy(port_rb_busy),
    .port_synced(port_synced), .port_err(port_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic buf_put(input int idx, input logic [31:0] d);
    bm[idx] = d;
    bus_wr(12'(idx * 4), d);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 400; i++) begin
      bus_rd(A_STAT, s);
      if (s[0]) break;
    end
    chk("R5 done reached", {31'b0, s[0]}, 32'd1);
  endtask

  // Driver: queue the expected outgoing words, then program and launch.
  task automatic run_cfg(input int first, input int nw);
    for (int i = 0; i < nw; i++) expq.push_back(bm[(first + i) % 512]);
    bus_wr(A_LEN, 32'(nw * 4));
    bus_wr(A_FIRST, 32'(first));
    bus_wr(A_DIR, 32'd0);
  endtask

  // Port-side readback source with optional idle gaps.
  task automatic rb_feed(input int first, input int nw, input bit gaps);
    int i;
    i = 0;
    while (i < nw) begin
      rb_in_valid = 1'b1;
      rb_in_data  = 32'hC0DE0000 + 32'(i);
      @(negedge clk);
      if (rb_in_ready) begin
        bm[(first + i) % 512] = rb_in_data;
        i++;
      end
      @(posedge clk); #1;
      if (gaps && i[0]) begin
        rb_in_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    rb_in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    tick = tick + 1;
    case (rdy_mode)
      0:       cfg_out_ready = 1'b1;
      1:       cfg_out_ready = tick[0];
      default: cfg_out_ready = 1'b0;
    endcase
  end

  // Monitor: compare each accepted outgoing word with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cfg_out_valid && cfg_out_ready) begin
      if (expq.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R3 unexpected word actual %h expected none", cfg_out_data);
      end else begin
        chk("R3 stream word", cfg_out_data, expq.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // Reset state
    bus_rd(A_STAT, d);
    chk("R5 R6 status after reset", d, 32'h0000_00BF);
    chk("R4 ready idle", {31'b0, rb_in_ready}, 32'd0);
    chk("R3 valid idle", {31'b0, cfg_out_valid}, 32'd0);

    // R6 live flags
    port_abort_n = 1'b0; port_rb_busy = 1'b1; port_synced = 1'b0; port_err = 1'b1;
    bus_rd(A_STAT, d);
    chk("R6 flags", d, 32'h0000_015F);
    port_abort_n = 1'b1; port_rb_busy = 1'b0; port_synced = 1'b1; port_err = 1'b0;

    // R1 buffer access
    for (int i = 0; i < 16; i++) buf_put(i, 32'hA5000000 + 32'(i) * 32'h1111);
    buf_put(105, 32'h1234_5678);
    buf_put(510, 32'h0510_0510);
    buf_put(511, 32'h0511_0511);
    buf_put(104, 32'hDEAD_0104);
    bus_rd(12'h00C, d);
    chk("R1 word 3", d, bm[3]);
    bus_rd(12'h7FC, d);
    chk("R1 word 511", d, bm[511]);

    // R2 register readback
    bus_wr(A_LEN, 32'hCAFE_F00D);
    bus_rd(A_LEN, d);
    chk("R2 length", d, 32'hCAFE_F00D);
    bus_wr(A_FIRST, 32'h0000_03F5);
    bus_rd(A_FIRST, d);
    chk("R2 start index", d, 32'h0000_01F5);

    // R3 configure, ready always high
    rdy_mode = 0;
    run_cfg(0, 8);
    wait_done();
    chk("R3 all words sent", 32'(expq.size()), 32'd0);

    // R3 R5 configure with alternating ready
    rdy_mode = 1;
    run_cfg(5, 3);
    bus_rd(A_STAT, d);
    chk("R5 busy bit", {31'b0, d[0]}, 32'd0);
    wait_done();
    chk("R3 throttled stream", 32'(expq.size()), 32'd0);

    // R8 wrap
    rdy_mode = 0;
    run_cfg(510, 4);
    wait_done();
    chk("R8 wrap stream", 32'(expq.size()), 32'd0);

    // R4 readback with gaps
    bus_wr(A_LEN, 32'd20);
    bus_wr(A_FIRST, 32'd100);
    bus_wr(A_DIR, 32'd1);
    rb_feed(100, 5, 1'b1);
    @(posedge clk); #1;
    bus_rd(A_STAT, d);
    chk("R4 R5 readback done", {31'b0, d[0]}, 32'd1);
    for (int i = 100; i < 106; i++) begin
      bus_rd(12'(i * 4), d);
      chk("R4 buffer after readback", d, bm[i]);
    end
    chk("R4 untouched word", bm[105], 32'h1234_5678);

    // R8 readback across the wrap
    bus_wr(A_LEN, 32'd12);
    bus_wr(A_FIRST, 32'd511);
    bus_wr(A_DIR, 32'd1);
    rb_feed(511, 3, 1'b0);
    @(posedge clk); #1;
    bus_rd(12'h000, d);
    chk("R8 readback wrap word 0", d, bm[0]);
    bus_rd(12'h7FC, d);
    chk("R8 readback word 511", d, bm[511]);

    // R7 sub-word length
    bus_wr(A_LEN, 32'd3);
    bus_wr(A_DIR, 32'd0);
    chk("R7 no valid", {31'b0, cfg_out_valid}, 32'd0);
    bus_rd(A_STAT, d);
    chk("R7 done stays", {31'b0, d[0]}, 32'd1);

    // R9 direction write while busy
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    run_cfg(0, 2);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 valid held", {31'b0, cfg_out_valid}, 32'd1);
    bus_wr(A_DIR, 32'd1);
    @(negedge clk);
    chk("R9 no readback", {31'b0, rb_in_ready}, 32'd0);
    chk("R9 still configuring", {31'b0, cfg_out_valid}, 32'd1);
    @(posedge clk); #1;
    rdy_mode = 0;
    wait_done();
    chk("R9 original stream done", 32'(expq.size()), 32'd0);

    // R10 abort
    rdy_mode = 2;
    repeat (2) @(posedge clk);
    #1;
    bus_wr(A_LEN, 32'd40);
    bus_wr(A_FIRST, 32'd0);
    bus_wr(A_DIR, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    bus_wr(A_STAT, 32'h0000_FEFE);
    chk("R10 valid dropped", {31'b0, cfg_out_valid}, 32'd0);
    bus_rd(A_STAT, d);
    chk("R10 done set", {31'b0, d[0]}, 32'd1);
    bus_rd(12'h000, d);
    chk("R10 buffer kept", d, bm[0]);
    bus_wr(A_LEN, 32'd20);
    bus_wr(A_FIRST, 32'd100);
    bus_wr(A_DIR, 32'd1);
    @(negedge clk);
    chk("R10 readback started", {31'b0, rb_in_ready}, 32'd1);
    @(posedge clk); #1;
    bus_wr(A_STAT, 32'h0000_FEFE);
    chk("R10 ready dropped", {31'b0, rb_in_ready}, 32'd0);
    bus_rd(12'(100 * 4), d);
    chk("R10 buffer kept rb", d, bm[100]);

    rdy_mode = 1;
    run_cfg(2, 2);
    wait_done();
    chk("R10 works after abort", 32'(expq.size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule